// File: doc/BRIEF.md
# NX Range Set/Clear Sequencer

This block turns one range command into a run of single-address no-execute flag updates. Software, or an instruction decoder, gives it a low address, a high address and a selector that says whether the range is to become non-executable or executable again, and pulses a start input. The sequencer then walks the range upward one 256-byte granule at a time. For each granule it sends one update request to the flag unit and waits for that unit's result code.

Each request carries the granule base address and a flag value. The flag value is 1 for a set command and 0 for a clear command. When every step reports code zero, the sequencer pulses done with a zero status. When a step returns a nonzero code, it stops at once. It reports that code and the granule address that failed, and it leaves earlier updates as they are. An inverted range (low above high) completes without any request.

Top module: `nx_range_seq`

## Requirements
- R1: After reset, busy_o, done_o and req_valid_o are low, and status_o and fail_addr_o are zero.
- R2: For a command with lo_addr_i <= hi_addr_i, one request is issued per granule. Request addresses are granule bases (the address with its low 8 bits zero). They go from the granule holding lo_addr_i up to and including the granule holding hi_addr_i, rising by 256 each step.
- R3: req_flag_o is 1 on every request of a command started with set_i = 1, and 0 on every request of a command started with set_i = 0.
- R4: While req_valid_o is high and req_ready_i is low, req_valid_o, req_addr_o and req_flag_o hold their values into the next cycle.
- R5: At most one request is outstanding. A request counts as accepted when req_valid_o and req_ready_i are both high. After that, no new request is raised until rsp_valid_i has returned a code for it.
- R6: When every step returns code 0, done_o pulses with status_o = 0 and fail_addr_o = 0.
- R7: On a nonzero rsp_code_i, the next cycle has done_o high with status_o equal to that code and fail_addr_o equal to the failing granule base. No further request is issued for that command.
- R8: If lo_addr_i > hi_addr_i, no request is issued. done_o pulses with status_o = 0.
- R9: A start_i pulse while busy_o is high has no effect on the running command or its results.
- R10: busy_o rises in the cycle after an accepted start and stays high through the done_o cycle. done_o is high for exactly one cycle. busy_o is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a range command |
| lo_addr_i | input | ADDR_W | Low boundary of the range |
| hi_addr_i | input | ADDR_W | High boundary of the range (inclusive) |
| set_i | input | 1 | 1 sets non-executable, 0 restores executable |
| busy_o | output | 1 | Command in progress |
| req_valid_o | output | 1 | Single-address update request valid |
| req_ready_i | input | 1 | Flag unit accepts the request |
| req_addr_o | output | ADDR_W | Granule base address of the request |
| req_flag_o | output | 1 | Flag value to write |
| rsp_valid_i | input | 1 | Result code valid |
| rsp_code_i | input | CODE_W | Result code, zero means success |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | CODE_W | Zero, or the first nonzero code |
| fail_addr_o | output | ADDR_W | Granule base of the failing step, else zero |

## Verification
The assertions watch the handshake every cycle. They check that a stalled request holds still, that only one request is outstanding, that accepted addresses rise by exactly one granule within a command, and that no request appears while idle. They also check that done is a single-cycle pulse inside busy, and that an error code is followed at once by done carrying it. The bench scenarios are needed for the rest. Those are the exact first and last granule of ragged ranges, the flag value against the selector, inverted ranges, the reported failing address, and that a start arriving mid-command leaves the logged request stream unchanged.

// File: rtl/nx_seq_pkg.sv
package nx_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/nx_seq_walker.sv
module nx_seq_walker #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              last_o
);
  localparam int IDX_W = ADDR_W - GRAN_LG2;

  logic [IDX_W-1:0] cur_q, cur_d;
  logic [IDX_W-1:0] end_q, end_d;

  always_comb begin
    cur_d = cur_q;
    end_d = end_q;
    if (load_i) begin
      cur_d = lo_i[ADDR_W-1:GRAN_LG2];
      end_d = hi_i[ADDR_W-1:GRAN_LG2];
    end else if (step_i) begin
      cur_d = cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      end_q <= '0;
    end else if (load_i || step_i) begin
      cur_q <= cur_d;
      end_q <= end_d;
    end
  end

  assign cur_addr_o = {cur_q, {GRAN_LG2{1'b0}}};
  assign last_o     = (cur_q == end_q);
endmodule

// File: rtl/nx_seq_result.sv
module nx_seq_result #(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CODE_W-1:0] status_o,
  output logic [ADDR_W-1:0] fail_addr_o
);
  logic [CODE_W-1:0] stat_d;
  logic [ADDR_W-1:0] fadr_d;
  logic              en;

  assign en = clr_i || cap_i;

  always_comb begin
    stat_d = '0;
    fadr_d = '0;
    if (cap_i) begin
      stat_d = code_i;
      fadr_d = addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o    <= '0;
      fail_addr_o <= '0;
    end else if (en) begin
      status_o    <= stat_d;
      fail_addr_o <= fadr_d;
    end
  end
endmodule

// File: rtl/nx_seq_ctrl.sv
module nx_seq_ctrl
  import nx_seq_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              empty_i,
  input  logic              set_i,
  input  logic              req_ready_i,
  input  logic              rsp_valid_i,
  input  logic [CODE_W-1:0] rsp_code_i,
  input  logic              last_i,
  output logic              load_o,
  output logic              step_o,
  output logic              clr_o,
  output logic              cap_o,
  output logic              req_valid_o,
  output logic              flag_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_t st_q, st_d;
  logic       flag_q;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    step_o = 1'b0;
    clr_o  = 1'b0;
    cap_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o = 1'b1;
          clr_o  = 1'b1;
          st_d   = empty_i ? ST_FIN : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (req_ready_i) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid_i) begin
          if (rsp_code_i != '0) begin
            cap_o = 1'b1;
            st_d  = ST_FIN;
          end else if (last_i) begin
            st_d  = ST_FIN;
          end else begin
            step_o = 1'b1;
            st_d   = ST_ISSUE;
          end
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (load_o) flag_q <= set_i;
  end

  assign req_valid_o = (st_q == ST_ISSUE);
  assign flag_o      = flag_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_FIN);
endmodule

// File: rtl/nx_range_seq.sv
module nx_range_seq #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LG2 = 8,
  parameter int CODE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] lo_addr_i,
  input  logic [ADDR_W-1:0] hi_addr_i,
  input  logic              set_i,
  output logic              busy_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              req_flag_o,
  input  logic              rsp_valid_i,
  input  logic [CODE_W-1:0] rsp_code_i,
  output logic              done_o,
  output logic [CODE_W-1:0] status_o,
  output logic [ADDR_W-1:0] fail_addr_o
);
  logic load, step, clr, cap, last, empty;

  assign empty = (lo_addr_i > hi_addr_i);

  nx_seq_ctrl #(.CODE_W(CODE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .empty_i(empty),
    .set_i(set_i), .req_ready_i(req_ready_i), .rsp_valid_i(rsp_valid_i),
    .rsp_code_i(rsp_code_i), .last_i(last), .load_o(load), .step_o(step),
    .clr_o(clr), .cap_o(cap), .req_valid_o(req_valid_o), .flag_o(req_flag_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  nx_seq_walker #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) walk_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
    .lo_i(lo_addr_i), .hi_i(hi_addr_i), .cur_addr_o(req_addr_o), .last_o(last)
  );

  nx_seq_result #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) res_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .cap_i(cap), .code_i(rsp_code_i),
    .addr_i(req_addr_o), .status_o(status_o), .fail_addr_o(fail_addr_o)
  );
endmodule

// File: rtl/nx_range_seq_chk.sv
module nx_range_seq_chk #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LG2 = 8,
  parameter int CODE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              req_flag_o,
  input logic              rsp_valid_i,
  input logic [CODE_W-1:0] rsp_code_i,
  input logic              done_o,
  input logic [CODE_W-1:0] status_o
);
  localparam logic [ADDR_W-1:0] GSTEP = ADDR_W'(1) << GRAN_LG2;

  logic              outst_q;
  logic              seen_q;
  logic [ADDR_W-1:0] last_q;
  logic              acc;

  assign acc = req_valid_o && req_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
      seen_q  <= 1'b0;
      last_q  <= '0;
    end else begin
      if (acc) outst_q <= 1'b1;
      else if (rsp_valid_i) outst_q <= 1'b0;
      if (done_o) seen_q <= 1'b0;
      else if (acc) seen_q <= 1'b1;
      if (acc) last_q <= req_addr_o;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_flag_o)); // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !req_valid_o); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && seen_q |-> req_addr_o == last_q + GSTEP); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !req_valid_o && !done_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o); // R10
  AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q && rsp_valid_i && rsp_code_i != '0 |=> done_o && status_o == $past(rsp_code_i)); // R7
endmodule

bind nx_range_seq nx_range_seq_chk #(
  .ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2), .CODE_W(CODE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i), .req_addr_o(req_addr_o), .req_flag_o(req_flag_o),
  .rsp_valid_i(rsp_valid_i), .rsp_code_i(rsp_code_i), .done_o(done_o),
  .status_o(status_o)
);

// File: tb/nx_range_seq_tb_top.sv
module nx_range_seq_tb_top;
  localparam int NV = 7;
  localparam logic [31:0] V_LO [NV] = '{32'h1000, 32'h1010, 32'h2000, 32'h3000, 32'h40F0, 32'h5000, 32'h7050};
  localparam logic [31:0] V_HI [NV] = '{32'h1000, 32'h13FF, 32'h24FF, 32'h2FFF, 32'h4105, 32'h57FF, 32'h7040};
  localparam logic        V_SET[NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam int          V_FA [NV] = '{99, 99, 2, 99, 99, 0, 99};
  localparam logic [3:0]  V_FC [NV] = '{4'h0, 4'h0, 4'h5, 4'h0, 4'h0, 4'hF, 4'h0};
  localparam int          V_LAT[NV] = '{0, 1, 0, 1, 2, 1, 0};

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, set_i, req_ready_i, rsp_valid_i;
  logic [31:0] lo_addr_i, hi_addr_i;
  logic [3:0]  rsp_code_i;
  logic busy_o, req_valid_o, req_flag_o, done_o;
  logic [31:0] req_addr_o, fail_addr_o;
  logic [3:0]  status_o;

  int n_chk = 0;
  int n_bad = 0;

  int          lat = 0, fail_at = 99, stepn = 0, nlog = 0, rdy_cnt = 0, dly = 0;
  logic [3:0]  fail_code = 4'h0;
  logic        pend = 1'b0;
  logic [31:0] log_addr [64];
  logic        log_flag [64];

  always #2.5 clk = ~clk;

  nx_range_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lo_addr_i(lo_addr_i),
    .hi_addr_i(hi_addr_i), .set_i(set_i), .busy_o(busy_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .req_flag_o(req_flag_o), .rsp_valid_i(rsp_valid_i), .rsp_code_i(rsp_code_i),
    .done_o(done_o), .status_o(status_o), .fail_addr_o(fail_addr_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // flag unit model: one request at a time, latency 'lat'
  initial begin
    req_ready_i = 1'b0;
    rsp_valid_i = 1'b0;
    rsp_code_i  = 4'h0;
    forever begin
      @(negedge clk);
      rsp_valid_i = 1'b0;
      rsp_code_i  = 4'h0;
      if (req_ready_i) begin
        req_ready_i = 1'b0;
        pend = 1'b1;
        dly  = lat;
      end else if (pend) begin
        if (dly == 0) begin
          rsp_valid_i = 1'b1;
          rsp_code_i  = (stepn == fail_at) ? fail_code : 4'h0;
          pend  = 1'b0;
          stepn++;
        end else dly--;
      end else if (req_valid_o) begin
        if (rdy_cnt >= lat) begin
          req_ready_i = 1'b1;
          if (nlog < 64) begin
            log_addr[nlog] = req_addr_o;
            log_flag[nlog] = req_flag_o;
          end
          nlog++;
          rdy_cnt = 0;
        end else rdy_cnt++;
      end
    end
  end

  task automatic issue(input logic [31:0] lo, input logic [31:0] hi, input logic s);
    @(negedge clk);
    lo_addr_i = lo; hi_addr_i = hi; set_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int seen);
    seen = 0;
    for (int i = 0; i < 2000 && !done_o; i++) @(negedge clk);
    seen = done_o ? 1 : 0;
  endtask

  task automatic run_cmd(input logic [31:0] lo, input logic [31:0] hi, input logic s,
                         input int fa, input logic [3:0] fc, input int l);
    int seen, ntot, nexp, g0;
    logic [3:0]  est;
    logic [31:0] efa;
    lat = l; fail_at = fa; fail_code = fc; stepn = 0; nlog = 0; rdy_cnt = 0;
    g0 = int'(lo >> 8);
    if (lo > hi) ntot = 0;
    else ntot = int'(hi >> 8) - g0 + 1;
    if (fa < ntot && fc != 4'h0) begin
      nexp = fa + 1; est = fc; efa = 32'(g0 + fa) << 8;
    end else begin
      nexp = ntot; est = 4'h0; efa = 32'h0;
    end
    issue(lo, hi, s);
    chk(busy_o == 1'b1, "R10 busy after start", 32'(busy_o), 32'd1);
    wait_done(seen);
    chk(seen == 1, "R10 done reached", 32'(seen), 32'd1);
    if (lo > hi) chk(status_o == 4'h0, "R8 inverted range status", 32'(status_o), 32'h0);
    else if (est != 0) chk(status_o == est, "R7 error status", 32'(status_o), 32'(est));
    else chk(status_o == 4'h0, "R6 success status", 32'(status_o), 32'h0);
    chk(fail_addr_o == efa, (est != 0) ? "R7 failing address" : "R6 fail address zero", fail_addr_o, efa);
    @(negedge clk);
    chk(!done_o && !busy_o, "R10 done single cycle, busy drops", {30'd0, done_o, busy_o}, 32'h0);
    chk(nlog == nexp, (lo > hi) ? "R8 no requests" : "R2/R7 request count", 32'(nlog), 32'(nexp));
    for (int k = 0; k < nlog && k < nexp; k++) begin
      chk(log_addr[k] == (32'(g0 + k) << 8), "R2 request address", log_addr[k], 32'(g0 + k) << 8);
      chk(log_flag[k] == s, "R3 request flag", 32'(log_flag[k]), 32'(s));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seen;
    rst_n = 1'b0; start_i = 1'b0; set_i = 1'b0; lo_addr_i = '0; hi_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !req_valid_o, "R1 reset outputs low",
        {29'd0, busy_o, done_o, req_valid_o}, 32'h0);
    chk(status_o == 4'h0 && fail_addr_o == 32'h0, "R1 reset status zero", fail_addr_o | 32'(status_o), 32'h0);

    for (int v = 0; v < NV; v++)
      run_cmd(V_LO[v], V_HI[v], V_SET[v], V_FA[v], V_FC[v], V_LAT[v]);

    // R9: start while busy is ignored
    lat = 2; fail_at = 99; fail_code = 4'h0; stepn = 0; nlog = 0; rdy_cnt = 0;
    issue(32'h8000, 32'h83FF, 1'b1);
    repeat (3) @(negedge clk);
    lo_addr_i = 32'h9000; hi_addr_i = 32'h9000; set_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(seen);
    chk(seen == 1 && status_o == 4'h0, "R9 first command completes", 32'(status_o), 32'h0);
    @(negedge clk);
    @(negedge clk);
    chk(!busy_o, "R9 late start not latched", 32'(busy_o), 32'h0);
    chk(nlog == 4, "R9 request count unchanged", 32'(nlog), 32'd4);
    for (int k = 0; k < 4 && k < nlog; k++) begin
      chk(log_addr[k] == 32'h8000 + 32'(k * 256), "R9 address stream", log_addr[k], 32'h8000 + 32'(k * 256));
      chk(log_flag[k] == 1'b1, "R9 flag stream", 32'(log_flag[k]), 32'd1);
    end

    // R6 after an error run: status clears on a new successful command
    run_cmd(32'hA000, 32'hA1FF, 1'b0, 99, 4'h0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule